// File: doc/BRIEF.md
# Debug-Mode Run-State Controller

This block follows the run state of one processor core that can be stopped by an external debugger. It keeps one of four states: running, waiting for a wake condition, halted in debug mode, and halted while carrying out a debugger abstract command. State changes come from the retirement stream of the core, a wake signal, a two-bit request from the debugger and a command-start strobe.

The core's execute stage reports each retiring instruction word, with a flag that tells whether it trapped. The controller decodes the words it needs to act on. The current privilege level, the three per-privilege breakpoint enables and the single-step bit come in from the debug control register, which is held outside this block. The block drives the run state, one-cycle pulses on entry to and exit from debug mode, the cause of the last entry, and a command-error flag that stays set until the debugger clears it. It also drives a pulse that tells the core to take an ordinary breakpoint trap. Every output is registered and changes on the clock edge after the cycle that caused it.

Top module: `dbgmode_ctrl`

## Requirements
- R1: After reset the run state is 0 (running), the command-error flag, both pulses and the trap pulse are low, and the entry cause is 0.
- R2: In the running state (0), a retired wait instruction moves the state to waiting (1). The wait instructions are WFI 0x10500073, WRS.NTO 0x00D00073 and WRS.STO 0x01D00073. While waiting, a high wakeUp returns the state to running.
- R3: With extEnable high, a halt request (dbgReq = 1) moves the state from running or waiting directly to debug (2), with entry cause 2. In the running state it wins over any retirement in the same cycle.
- R4: A retired EBREAK (0x00100073) in the running state picks its enable by privilege: ebreakEnU for 0, ebreakEnS for 1, ebreakEnM for 3, and none for 2. If extEnable and the picked enable are both high, the state moves to debug with cause 1. Otherwise brkTrap pulses for one cycle and the state stays running.
- R5: With extEnable and stepEnable high, any instruction that retires without a trap in the running state moves the state to debug with cause 3. A WFI retired while stepping does not move the state to waiting.
- R6: In debug, a cmdStart strobe moves the state to abstract command (3).
- R7: In abstract command, a retired EBREAK returns the state to debug. No trap pulse is raised and the error flag is not set.
- R8: In abstract command, a retirement with retireExc high returns the state to debug and sets cmdErr. cmdErr stays high until errClear. A set and a clear in the same cycle leave it set.
- R9: A resume request (dbgReq = 2) in debug or abstract command returns the state to running. A DRET (0x7B200073) retired in debug with extEnable high also returns it to running. A DRET in abstract command, or in any state with extEnable low, has no effect.
- R10: A WFI retired in abstract command leaves the state unchanged.
- R11: enterPulse is high for exactly the first cycle in debug after leaving running or waiting. exitPulse is high for exactly the first cycle in running after leaving debug or abstract command. entryCause holds its value until the next entry.
- R12: A request of none (0) leaves the state unchanged. A halt request in debug or abstract command, a resume request in running, and a halt request with extEnable low all have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extEnable | input | 1 | Debug extension enabled |
| privLvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| ebreakEnU | input | 1 | EBREAK enters debug from user level |
| ebreakEnS | input | 1 | EBREAK enters debug from supervisor level |
| ebreakEnM | input | 1 | EBREAK enters debug from machine level |
| stepEnable | input | 1 | Single-step bit |
| retireValid | input | 1 | An instruction finishes this cycle |
| retireExc | input | 1 | The finishing instruction trapped |
| retireWord | input | 32 | Encoding of the finishing instruction |
| wakeUp | input | 1 | Wake condition for the waiting state |
| dbgReq | input | 2 | Debugger request: 0 none, 1 halt, 2 resume |
| cmdStart | input | 1 | Start an abstract command |
| errClear | input | 1 | Clear the command-error flag |
| runState | output | 2 | 0 running, 1 waiting, 2 debug, 3 abstract command |
| enterPulse | output | 1 | One-cycle debug entry pulse |
| exitPulse | output | 1 | One-cycle debug exit pulse |
| entryCause | output | 2 | Last entry cause: 1 EBREAK, 2 halt, 3 step |
| cmdErr | output | 1 | Sticky abstract-command error |
| brkTrap | output | 1 | One-cycle request for an ordinary breakpoint trap |

## Verification
Each output is one register stage away from its inputs. The state, both pulses, the entry cause, the error flag and the trap pulse driven by a stimulus in one cycle all appear on the next rising edge, and nothing is due later than that. The bench applies each stimulus on a falling edge and steps a behavioural reference model once per rising edge. At the next falling edge it compares all six outputs with the model, so every result is checked in the one cycle where it first becomes due.

// File: rtl/dbgmode_pkg.sv
package dbgmode_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_HALTED = 2'd2,
    ST_CMD    = 2'd3
  } runState_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_BRK  = 2'd1,
    CAUSE_HALT = 2'd2,
    CAUSE_STEP = 2'd3
  } cause_e;

  localparam logic [1:0] REQ_NONE   = 2'd0;
  localparam logic [1:0] REQ_HALT   = 2'd1;
  localparam logic [1:0] REQ_RESUME = 2'd2;

  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  localparam logic [31:0] OP_EBREAK  = 32'h0010_0073;
  localparam logic [31:0] OP_DRET    = 32'h7B20_0073;
  localparam logic [31:0] OP_WFI     = 32'h1050_0073;
  localparam logic [31:0] OP_WRS_NTO = 32'h00D0_0073;
  localparam logic [31:0] OP_WRS_STO = 32'h01D0_0073;

  // decoded view of the retiring instruction
  typedef struct packed {
    logic ok;      // retired without trap
    logic fault;   // retired with trap
    logic ebreak;
    logic dret;
    logic waitOp;
  } retireInfo_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic   enter;
    logic   leave;
    logic   setErr;
    logic   trap;
    cause_e cause;
  } ctlStrobe_t;

endpackage

// File: rtl/dbgmode_decode.sv
module dbgmode_decode
  import dbgmode_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               retireValid,
  input  logic               retireExc,
  input  logic [INSTR_W-1:0] retireWord,
  output retireInfo_t        info
);
  localparam int CMP_W = (INSTR_W < 32) ? INSTR_W : 32;

  logic [31:0] word32;

  always_comb begin
    word32 = '0;
    word32[CMP_W-1:0] = retireWord[CMP_W-1:0];
  end

  always_comb begin
    info.ok     = retireValid && !retireExc;
    info.fault  = retireValid && retireExc;
    info.ebreak = info.ok && (word32 == OP_EBREAK);
    info.dret   = info.ok && (word32 == OP_DRET);
    info.waitOp = info.ok && ((word32 == OP_WFI) || (word32 == OP_WRS_NTO) ||
                              (word32 == OP_WRS_STO));
  end
endmodule

// File: rtl/dbgmode_fsm.sv
module dbgmode_fsm
  import dbgmode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        extEnable,
  input  logic [1:0]  privLvl,
  input  logic [2:0]  ebreakEn,   // [0] user, [1] supervisor, [2] machine
  input  logic        stepEnable,
  input  retireInfo_t info,
  input  logic        wakeUp,
  input  logic [1:0]  dbgReq,
  input  logic        cmdStart,
  output runState_e   state,
  output ctlStrobe_t  strobe
);
  runState_e nextState;
  logic      brkAllowed;
  logic      haltReq;
  logic      resumeReq;

  assign haltReq   = extEnable && (dbgReq == REQ_HALT);
  assign resumeReq = (dbgReq == REQ_RESUME);

  always_comb begin
    unique case (privLvl)
      PRIV_USER:  brkAllowed = ebreakEn[0];
      PRIV_SUPER: brkAllowed = ebreakEn[1];
      PRIV_MACH:  brkAllowed = ebreakEn[2];
      default:    brkAllowed = 1'b0;
    endcase
  end

  always_comb begin
    nextState = state;
    strobe    = '{enter: 1'b0, leave: 1'b0, setErr: 1'b0, trap: 1'b0,
                  cause: CAUSE_NONE};
    unique case (state)
      ST_RUN: begin
        if (haltReq) begin
          nextState = ST_HALTED; strobe.enter = 1'b1; strobe.cause = CAUSE_HALT;
        end else if (info.ebreak) begin
          if (extEnable && brkAllowed) begin
            nextState = ST_HALTED; strobe.enter = 1'b1; strobe.cause = CAUSE_BRK;
          end else begin
            strobe.trap = 1'b1;
          end
        end else if (extEnable && stepEnable && info.ok) begin
          nextState = ST_HALTED; strobe.enter = 1'b1; strobe.cause = CAUSE_STEP;
        end else if (info.waitOp) begin
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (haltReq) begin
          nextState = ST_HALTED; strobe.enter = 1'b1; strobe.cause = CAUSE_HALT;
        end else if (wakeUp) begin
          nextState = ST_RUN;
        end
      end
      ST_HALTED: begin
        if (resumeReq || (extEnable && info.dret)) begin
          nextState = ST_RUN; strobe.leave = 1'b1;
        end else if (cmdStart) begin
          nextState = ST_CMD;
        end
      end
      ST_CMD: begin
        if (resumeReq) begin
          nextState = ST_RUN; strobe.leave = 1'b1;
        end else if (info.fault) begin
          nextState = ST_HALTED; strobe.setErr = 1'b1;
        end else if (info.ebreak) begin
          nextState = ST_HALTED;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  // R3: an enabled halt from running or waiting lands in debug
  a_r3_halt_enters: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN || state == ST_WAIT) && extEnable && dbgReq == REQ_HALT)
      |=> (state == ST_HALTED));

  // R6: command start from debug without a competing exit
  a_r6_cmd_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALTED && dbgReq == REQ_NONE && !info.dret && cmdStart)
      |=> (state == ST_CMD));

  // R9: resume from either debug state goes back to running
  a_r9_resume: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_HALTED || state == ST_CMD) && dbgReq == REQ_RESUME)
      |=> (state == ST_RUN));

  // R10: a WFI inside a command never reaches the waiting state
  a_r10_no_wait_in_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD) |=> (state != ST_WAIT));

  // R12: an idle request with no events keeps the state
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dbgReq == REQ_NONE && !info.ok && !info.fault && !wakeUp && !cmdStart)
      |=> $stable(state));
endmodule

// File: rtl/dbgmode_dp.sv
module dbgmode_dp
  import dbgmode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       errClear,
  output logic       enterPulse,
  output logic       exitPulse,
  output cause_e     entryCause,
  output logic       cmdErr,
  output logic       brkTrap
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enterPulse <= 1'b0;
      exitPulse  <= 1'b0;
      brkTrap    <= 1'b0;
      entryCause <= CAUSE_NONE;
      cmdErr     <= 1'b0;
    end else begin
      enterPulse <= strobe.enter;
      exitPulse  <= strobe.leave;
      brkTrap    <= strobe.trap;
      if (strobe.enter) entryCause <= strobe.cause;
      if (strobe.setErr)  cmdErr <= 1'b1;
      else if (errClear)  cmdErr <= 1'b0;
    end
  end

  // R8: the error flag only falls through a clear request
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr && !errClear) |=> cmdErr);

  // R11: the cause is held between entries
  a_r11_cause_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.enter) |=> $stable(entryCause));
endmodule

// File: rtl/dbgmode_ctrl.sv
module dbgmode_ctrl
  import dbgmode_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extEnable,
  input  logic [1:0]         privLvl,
  input  logic               ebreakEnU,
  input  logic               ebreakEnS,
  input  logic               ebreakEnM,
  input  logic               stepEnable,
  input  logic               retireValid,
  input  logic               retireExc,
  input  logic [INSTR_W-1:0] retireWord,
  input  logic               wakeUp,
  input  logic [1:0]         dbgReq,
  input  logic               cmdStart,
  input  logic               errClear,
  output logic [1:0]         runState,
  output logic               enterPulse,
  output logic               exitPulse,
  output logic [1:0]         entryCause,
  output logic               cmdErr,
  output logic               brkTrap
);
  retireInfo_t info;
  ctlStrobe_t  strobe;
  runState_e   state;
  cause_e      cause;

  dbgmode_decode #(.INSTR_W(INSTR_W)) u_decode (
    .retireValid(retireValid), .retireExc(retireExc),
    .retireWord(retireWord), .info(info)
  );

  dbgmode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .extEnable(extEnable), .privLvl(privLvl),
    .ebreakEn({ebreakEnM, ebreakEnS, ebreakEnU}), .stepEnable(stepEnable),
    .info(info), .wakeUp(wakeUp), .dbgReq(dbgReq), .cmdStart(cmdStart),
    .state(state), .strobe(strobe)
  );

  dbgmode_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errClear(errClear),
    .enterPulse(enterPulse), .exitPulse(exitPulse), .entryCause(cause),
    .cmdErr(cmdErr), .brkTrap(brkTrap)
  );

  assign runState   = state;
  assign entryCause = cause;

  // R11: entry pulse coincides with the first debug cycle, exit with running
  a_r11_enter_in_debug: assert property (@(posedge clk) disable iff (!rstN)
    enterPulse |-> (runState == ST_HALTED));
  a_r11_exit_in_run: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> (runState == ST_RUN));
  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enterPulse, exitPulse, brkTrap}));
  // R4: a breakpoint trap leaves the core running
  a_r4_trap_stays_run: assert property (@(posedge clk) disable iff (!rstN)
    brkTrap |-> (runState == ST_RUN));
endmodule

// File: tb/dbgmode_ctrl_bench.sv
`timescale 1ns/1ps
module dbgmode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extEnable = 1'b1;
  logic [1:0]  privLvl = 2'd3;
  logic        ebreakEnU = 1'b0, ebreakEnS = 1'b0, ebreakEnM = 1'b0;
  logic        stepEnable = 1'b0;
  logic        retireValid = 1'b0, retireExc = 1'b0;
  logic [31:0] retireWord = 32'h0000_0013;
  logic        wakeUp = 1'b0;
  logic [1:0]  dbgReq = 2'd0;
  logic        cmdStart = 1'b0, errClear = 1'b0;
  logic [1:0]  runState, entryCause;
  logic        enterPulse, exitPulse, cmdErr, brkTrap;

  int checks = 0, errors = 0;
  bit done = 0;
  // reference model state
  int mState = 0, mCause = 0;
  bit mEnter = 0, mExit = 0, mErr = 0, mTrap = 0;

  localparam logic [31:0] I_EBREAK = 32'h0010_0073, I_DRET = 32'h7B20_0073,
                          I_WFI = 32'h1050_0073, I_WRSN = 32'h00D0_0073,
                          I_WRSS = 32'h01D0_0073, I_ADDI = 32'h0000_0013;

  always #2 clk = ~clk;

  dbgmode_ctrl u_dbgmode_ctrl (
    .clk(clk), .rstN(rstN), .extEnable(extEnable), .privLvl(privLvl),
    .ebreakEnU(ebreakEnU), .ebreakEnS(ebreakEnS), .ebreakEnM(ebreakEnM),
    .stepEnable(stepEnable), .retireValid(retireValid), .retireExc(retireExc),
    .retireWord(retireWord), .wakeUp(wakeUp), .dbgReq(dbgReq),
    .cmdStart(cmdStart), .errClear(errClear), .runState(runState),
    .enterPulse(enterPulse), .exitPulse(exitPulse), .entryCause(entryCause),
    .cmdErr(cmdErr), .brkTrap(brkTrap)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "runState", runState, mState);
    chk(tag, "enterPulse", enterPulse, mEnter);
    chk(tag, "exitPulse", exitPulse, mExit);
    chk(tag, "entryCause", entryCause, mCause);
    chk(tag, "cmdErr", cmdErr, mErr);
    chk(tag, "brkTrap", brkTrap, mTrap);
  endtask

  // advance one clock, stepping the model from the applied inputs
  task automatic tick(input string tag);
    bit ok, fault, halt, resume, allow;
    int ns;
    ok = retireValid && !retireExc;
    fault = retireValid && retireExc;
    halt = extEnable && dbgReq == 2'd1;
    resume = dbgReq == 2'd2;
    allow = (privLvl == 0 && ebreakEnU) || (privLvl == 1 && ebreakEnS) ||
            (privLvl == 3 && ebreakEnM);
    ns = mState; mEnter = 0; mExit = 0; mTrap = 0;
    if (mState == 0) begin
      if (halt) begin ns = 2; mEnter = 1; mCause = 2; end
      else if (ok && retireWord == I_EBREAK) begin
        if (extEnable && allow) begin ns = 2; mEnter = 1; mCause = 1; end
        else mTrap = 1;
      end
      else if (ok && extEnable && stepEnable) begin ns = 2; mEnter = 1; mCause = 3; end
      else if (ok && (retireWord == I_WFI || retireWord == I_WRSN || retireWord == I_WRSS))
        ns = 1;
    end else if (mState == 1) begin
      if (halt) begin ns = 2; mEnter = 1; mCause = 2; end
      else if (wakeUp) ns = 0;
    end else if (mState == 2) begin
      if (resume || (extEnable && ok && retireWord == I_DRET)) begin ns = 0; mExit = 1; end
      else if (cmdStart) ns = 3;
    end else begin
      if (resume) begin ns = 0; mExit = 1; end
      else if (fault) begin ns = 2; mErr = 1; end
      else if (ok && retireWord == I_EBREAK) ns = 2;
    end
    if (!(mState == 3 && !resume && fault) && errClear) mErr = 0;
    mState = ns;
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
    retireValid = 0; retireExc = 0; retireWord = I_ADDI;
    wakeUp = 0; dbgReq = 0; cmdStart = 0; errClear = 0;
  endtask

  task automatic retire(input logic [31:0] w, input bit exc);
    retireValid = 1; retireWord = w; retireExc = exc;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;
    compareAll("R1 reset");
    tick("R12 idle"); tick("R12 idle");

    // R2 waiting entry and wake
    retire(I_WFI, 0); tick("R2 wfi");
    tick("R2 hold"); wakeUp = 1; tick("R2 wake");
    retire(I_WRSS, 0); tick("R2 wrs.sto"); wakeUp = 1; tick("R2 wake");
    retire(I_WRSN, 0); tick("R2 wrs.nto"); wakeUp = 1; tick("R2 wake");

    // R3 halt wins over a retiring WFI; R11 pulses
    dbgReq = 1; retire(I_WFI, 0); tick("R3 halt");
    tick("R11 pulse drops");
    dbgReq = 1; tick("R12 halt in debug");
    dbgReq = 2; tick("R9 resume"); tick("R11 exit drops");

    // R4 breakpoint routing
    ebreakEnM = 1; privLvl = 3; retire(I_EBREAK, 0); tick("R4 ebreak M");
    dbgReq = 2; tick("R9 resume");
    privLvl = 0; retire(I_EBREAK, 0); tick("R4 ebreak U trap"); tick("R4 trap drops");
    privLvl = 1; ebreakEnS = 1; retire(I_EBREAK, 0); tick("R4 ebreak S");
    dbgReq = 2; tick("R9 resume");
    privLvl = 2; retire(I_EBREAK, 0); tick("R4 reserved priv trap");
    privLvl = 1; extEnable = 0; retire(I_EBREAK, 0); tick("R4 disabled trap");
    extEnable = 1;

    // R5 single step
    stepEnable = 1; retire(I_ADDI, 0); tick("R5 step");
    dbgReq = 2; tick("R9 resume");
    retire(I_WFI, 0); tick("R5 step wfi");
    dbgReq = 2; tick("R9 resume");
    retire(I_ADDI, 1); tick("R5 trapped no step");
    stepEnable = 0;

    // R6, R10, R9, R7 inside a command
    dbgReq = 1; tick("R3 halt");
    cmdStart = 1; tick("R6 cmd start");
    retire(I_WFI, 0); tick("R10 wfi in cmd");
    retire(I_DRET, 0); tick("R9 dret in cmd ignored");
    dbgReq = 1; tick("R12 halt in cmd");
    retire(I_EBREAK, 0); tick("R7 ebreak ends cmd");

    // R8 error flag
    cmdStart = 1; tick("R6 cmd start");
    retire(I_ADDI, 1); tick("R8 fault");
    tick("R8 sticky"); tick("R8 sticky");
    errClear = 1; tick("R8 clear");
    cmdStart = 1; tick("R6 cmd start");
    retire(I_ADDI, 1); errClear = 1; tick("R8 set beats clear");
    errClear = 1; tick("R8 clear");
    cmdStart = 1; tick("R6 cmd start");
    dbgReq = 2; tick("R9 resume from cmd");

    // R9 DRET from debug, and ignored when disabled
    dbgReq = 1; tick("R3 halt");
    retire(I_DRET, 0); tick("R9 dret");
    dbgReq = 1; tick("R3 halt");
    extEnable = 0; retire(I_DRET, 0); tick("R9 dret disabled");
    extEnable = 1; dbgReq = 2; tick("R9 resume");

    // R3 halt from waiting
    retire(I_WFI, 0); tick("R2 wfi");
    dbgReq = 1; wakeUp = 1; tick("R3 halt from wait");
    dbgReq = 2; tick("R9 resume");

    // R12 ignored requests
    dbgReq = 2; tick("R12 resume in run");
    extEnable = 0; dbgReq = 1; tick("R12 halt disabled");
    extEnable = 1; tick("R12 idle");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule